// File: doc/BRIEF.md
# Debug Trigger Context-Match Qualifier

This block holds the extra-qualification word of one debug trigger and decides whether that trigger may fire in the current machine context. Software writes the word through a single write port. The block keeps two fields. The first is a 3-bit mode selector that is legalized on every write. The second is a machine value that is compared against the live machine context register.

The output `qual_o` is combinational. The surrounding trigger logic ANDs it with its own address or data match. While the mode is "ignore", the trigger is never held back. While the mode is "match context", the trigger passes only when the stored value equals the low bits of the machine context input. All supervisor-side qualification fields are tied to zero.

The mode register is a two-state machine. The state `QM_IGNORE` (code 0) moves to `QM_MCTX` (code 4) on a write whose selector is 4 to 7. The state `QM_MCTX` moves back to `QM_IGNORE` on a write whose selector is 0 to 3. Without a write, either state holds.

Top module: `ctx_trigger_qual`

## Requirements
- R1: After reset is asserted, `rd_data` reads 0 and `qual_o` is 1, because the mode and the stored value are both 0.
- R2: A write whose selector field `wr_data[31:29]` is 0 stores mode 0, and one whose selector is 4 stores mode 4. Both take effect on the clock edge that samples `wr_en`.
- R3: A write with selector 1, 2 or 3 stores mode 0.
- R4: A write with selector 5, 6 or 7 stores mode 4.
- R5: While the stored mode is 0, `qual_o` is 1 for every machine context value.
- R6: While the stored mode is 4, `qual_o` is 1 exactly when the stored value equals `mctx_i[5:0]`.
- R7: Machine context bits above the value width (`mctx_i[31:6]`) never affect `qual_o`.
- R8: The readback `rd_data` places the mode in bits [31:29] and the value in bits [28:23]. Bits [22:0], which hold the supervisor mask, value and select positions, read back as 0 whatever was written.
- R9: A write stores `wr_data[28:23]` verbatim as the value. While `wr_en` is low, the mode and the value hold, whatever `wr_data` carries.
- R10: A change of `mctx_i` is reflected in `qual_o` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the extra-qualification word |
| wr_data | input | 32 | Word to be written |
| mctx_i | input | 32 | Live machine context register value |
| rd_data | output | 32 | Legalized readback of the stored word |
| qual_o | output | 1 | Trigger qualification, combinational |

## Verification
The hardest case to reach is a near-miss in match mode. Here the context agrees with the stored value in every compared bit but differs in the ignored upper bits, or it differs in a single compared bit. A folded selector write can also land in the same window. The stimulus stores a value through a write with an illegal selector. It then walks the context through equal, single-bit-off and upper-bits-only variants on consecutive cycles. Each cycle is checked against a behavioural model.

// File: rtl/ctxq_pkg.sv
package ctxq_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        QM_IGNORE = 3'd0,
        QM_MCTX   = 3'd4
    } qual_mode_e;
endpackage

// File: rtl/ctxq_mode_fsm.sv
module ctxq_mode_fsm
    import ctxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel_raw,
    output qual_mode_e       mode
);
    qual_mode_e state_q;
    qual_mode_e state_d;

    // next state: fold illegal codes onto the two legal ones
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (sel_raw)
                3'd0, 3'd1, 3'd2, 3'd3: state_d = QM_IGNORE;
                3'd4, 3'd5, 3'd6, 3'd7: state_d = QM_MCTX;
                default:                state_d = QM_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QM_IGNORE;
        else        state_q <= state_d;
    end

    assign mode = state_q;

    // R3
    fold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_raw != 3'd0 && sel_raw < 3'd4) |=> (mode == QM_IGNORE));

    // R4
    fold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_raw > 3'd4) |=> (mode == QM_MCTX));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode));
endmodule

// File: rtl/ctxq_value_reg.sv
module ctxq_value_reg #(
    parameter int VAL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] din,
    output logic [VAL_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= din;
    end

    // R9
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // R9
    value_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(din)));
endmodule

// File: rtl/ctxq_compare.sv
module ctxq_compare
    import ctxq_pkg::*;
#(
    parameter int VAL_W = 6
) (
    input  qual_mode_e       mode,
    input  logic [VAL_W-1:0] mval,
    input  logic [VAL_W-1:0] mctx_lo,
    output logic             qual
);
    logic [VAL_W-1:0] bit_eq;

    for (genvar i = 0; i < VAL_W; i++) begin : g_bit
        assign bit_eq[i] = ~(mval[i] ^ mctx_lo[i]);
    end

    always_comb begin
        unique case (mode)
            QM_IGNORE: qual = 1'b1;
            QM_MCTX:   qual = &bit_eq;
            default:   qual = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctx_trigger_qual.sv
module ctx_trigger_qual
    import ctxq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MVAL_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] mctx_i,
    output logic [XLEN-1:0] rd_data,
    output logic            qual_o
);
    localparam int SEL_LO = XLEN - SEL_W;
    localparam int MV_HI  = SEL_LO - 1;
    localparam int MV_LO  = SEL_LO - MVAL_W;
    localparam int PAD_W  = MV_LO;

    qual_mode_e        mode;
    logic [MVAL_W-1:0] mval_q;

    ctxq_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel_raw (wr_data[XLEN-1:SEL_LO]),
        .mode    (mode)
    );

    ctxq_value_reg #(.VAL_W(MVAL_W)) u_val (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .din   (wr_data[MV_HI:MV_LO]),
        .q     (mval_q)
    );

    ctxq_compare #(.VAL_W(MVAL_W)) u_cmp (
        .mode    (mode),
        .mval    (mval_q),
        .mctx_lo (mctx_i[MVAL_W-1:0]),
        .qual    (qual_o)
    );

    // supervisor fields are hard-wired to zero
    assign rd_data = {logic'(mode[2]), logic'(mode[1]), logic'(mode[0]), mval_q, {PAD_W{1'b0}}};

    logic unused_bits;
    assign unused_bits = ^{wr_data[PAD_W-1:0], mctx_i[XLEN-1:MVAL_W]};

    // R5
    ignore_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[XLEN-1:SEL_LO] == 3'd0) |-> qual_o);

    // R6
    mismatch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[XLEN-1:SEL_LO] == 3'd4 && rd_data[MV_HI:MV_LO] != mctx_i[MVAL_W-1:0]) |-> !qual_o);
endmodule

// File: tb/ctx_trigger_qual_bench.sv
module ctx_trigger_qual_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mctx_i = '0;
    logic [31:0] rd_data;
    logic        qual_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_mode = 0;
    int m_val = 0;

    always #2 clk = ~clk;

    ctx_trigger_qual u_ctx_trigger_qual (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .mctx_i(mctx_i), .rd_data(rd_data), .qual_o(qual_o)
    );

    task automatic report_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // behavioural reference, compared every cycle
    always @(posedge clk) begin
        logic [31:0] exp_rd;
        logic        exp_q;
        int          sel;
        if (!rst_n) begin
            m_mode = 0; m_val = 0;
        end else if (wr_en) begin
            sel = int'(wr_data[31:29]);
            m_mode = (sel >= 4) ? 4 : 0;
            m_val  = int'(wr_data[28:23]);
        end
        #1;
        exp_rd = (32'(m_mode) << 29) | (32'(m_val) << 23);
        exp_q  = (m_mode == 0) ? 1'b1 : (m_val == int'(mctx_i % 64));
        compared++;
        if (rd_data !== exp_rd) begin
            mismatched++;
            $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, exp_rd);
        end
        compared++;
        if (qual_o !== exp_q) begin
            mismatched++;
            $display("FAIL %s qual_o actual=%b expected=%b ctx=%h", cur_req, qual_o, exp_q, mctx_i);
        end
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            report_end();
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [5:0] v, input logic [22:0] pad);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {sel, v, pad};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctx(input logic [31:0] c);
        @(negedge clk);
        mctx_i = c;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctx(32'h0000_0011);
        // R2
        cur_req = "R2";
        wr(3'd4, 6'd9, '0);
        ctx(32'd9); ctx(32'd8);
        wr(3'd0, 6'd5, '0);
        ctx(32'd5); ctx(32'd3);
        // R3
        cur_req = "R3";
        for (int s = 1; s < 4; s++) begin
            wr(3'd4, 6'd1, '0);
            wr(3'(s), 6'(s + 20), '0);
            ctx(32'd0); ctx(32'(s + 20));
        end
        // R4
        cur_req = "R4";
        for (int s = 5; s < 8; s++) begin
            wr(3'd0, 6'd2, '0);
            wr(3'(s), 6'(s + 40), '0);
            ctx(32'(s + 40)); ctx(32'(s + 41));
        end
        // R8
        cur_req = "R8";
        wr(3'd7, 6'h3F, 23'h7F_FFFF);
        ctx(32'hFFFF_FFFF);
        wr(3'd2, 6'h15, 23'h55_5555);
        // R5
        cur_req = "R5";
        for (int c = 0; c < 64; c += 7) ctx(32'(c) | 32'hA000_0000);
        // R6 / R7 near-miss walk after a folded write
        cur_req = "R6";
        wr(3'd6, 6'h2A, 23'h12_3456);
        ctx(32'h0000_002A); ctx(32'h0000_002B); ctx(32'h0000_000A); ctx(32'h0000_002A);
        cur_req = "R7";
        ctx(32'hFFFF_FFEA); ctx(32'h8000_0040 | 32'h2A); ctx(32'h0000_00AA);
        // R10: context changes every cycle, no write
        cur_req = "R10";
        for (int c = 40; c < 46; c++) ctx(32'(c));
        // R9: data toggles with strobe low
        cur_req = "R9";
        @(negedge clk); wr_data = 32'h0000_0000;
        @(negedge clk); wr_data = 32'hFFFF_FFFF;
        @(negedge clk); wr_data = 32'h8B80_0000;
        ctx(32'h2A);
        // R1 again: mid-run reset
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        mctx_i = 32'h5;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ctx(32'h3F);
        repeat (2) @(negedge clk);
        report_end();
    end
endmodule